// File: doc/BRIEF.md
# Microcode ALU with Opcode Decoder

This block takes one 32-bit microcode word per cycle, decodes it and produces a 32-bit result for a register-file write-back. It drives two 5-bit read indices straight from the word, so that an external register file can return both operands in the same cycle. The result, destination index, write enable and repeat flag are registered and appear one clock after the word is accepted.

Two instruction shapes are understood. The first combines one source register with a 16-bit zero-extended immediate. The second combines two source registers and picks the operation with a 5-bit selector. The 6-bit header uses a variable-length opcode. Headers below 0x30 carry a 5-bit opcode plus a repeat bit. Headers at 0x30 or above are control opcodes, which this block does not execute. A one-bit carry/borrow flag is kept between instructions so that 64-bit add and subtract can be done as a low half followed by a high half.

Top module: `mcode_alu`

## Requirements
- R1: The header is instr[31:26]. When it is below 0x30, the opcode is header[5:1] and rep_flag takes header[0]. When it is 0x30 or above, rep_flag is 0 and wr_en is 0.
- R2: Outputs are registered. A word accepted with instr_valid at a clock edge sets wr_en, wr_idx and wr_data after that edge. When instr_valid is low, wr_en is 0 on the following cycle.
- R3: In the immediate format, instr[15:0] is the zero-extended immediate, instr[20:16] is the destination and instr[25:21] is the source. ADD (0x01), SUB (0x03), AND (0x05), OR (0x06) and XOR (0x07) combine the source with the immediate.
- R4: ADD loads the flag with its carry-out and SUB loads it with its borrow (source < operand, unsigned). ADDHI (0x02) returns source+operand+flag and SUBHI (0x04) returns source-operand-flag. All other operations leave the flag unchanged.
- R5: SHL (0x09), USHR (0x0a, zero fill), ISHR (0x0b, sign fill) and ROT (0x0c, left rotate) shift by the operand's low 5 bits.
- R6: NOT (0x08) returns the bitwise inverse of the second operand, whatever the source holds. MUL8 (0x0d) returns the product of the low 8 bits of both operands.
- R7: MIN (0x0e) and MAX (0x0f) are unsigned. CMP (0x10) returns 0 when the values are equal, 1 when the source is greater and 2 when it is smaller, compared unsigned.
- R8: MOVI (0x11) writes the immediate shifted left by instr[25:21].
- R9: Opcode 0x13 is the two-register format. The selector is in [4:0], the destination in [15:11], src2 in [20:16] and src1 in [25:21]. Bits [10:5] have no effect. src_a_idx always shows [25:21] and src_b_idx always shows [20:16].
- R10: Selector 0x14 in the two-register format returns the index of the highest set bit of src2, or 0 when src2 is 0. Opcode 0x14 in the immediate format does not write.
- R11: NOP (0x00), the immediate opcodes 0x12 to 0x15, and two-register selectors other than 0x01 to 0x10 and 0x14 leave wr_en low.
- R12: Reset (synchronous, active high) clears wr_en, rep_flag and the carry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Word on instr is accepted at this edge |
| instr | input | 32 | Microcode word |
| src_a_idx | output | 5 | Read index of the first operand, instr[25:21] |
| src_b_idx | output | 5 | Read index of the second operand, instr[20:16] |
| src_a_data | input | 32 | Register value at src_a_idx |
| src_b_data | input | 32 | Register value at src_b_idx |
| wr_en | output | 1 | Registered write enable |
| wr_idx | output | 5 | Registered destination index |
| wr_data | output | 32 | Registered result |
| rep_flag | output | 1 | Registered repeat bit of the last accepted word |

## Verification
The only hidden state is the carry/borrow flag. A wrong flag value stays invisible until the next ADDHI or SUBHI, where the upper-half result is off by exactly one. For this reason, the carry sequences insert an unrelated instruction between the low and high halves, and the first ADDHI after reset checks the cleared state. Decode faults show up one cycle after the word is accepted, as a wrong wr_idx, a spurious or missing wr_en, or a wrong rep_flag.

// File: rtl/mcalu_pkg.sv
package mcalu_pkg;
  localparam logic [5:0] CTRL_HDR_BASE = 6'h30;

  localparam logic [4:0] OP_NOP   = 5'h00;
  localparam logic [4:0] OP_ADD   = 5'h01;
  localparam logic [4:0] OP_ADDHI = 5'h02;
  localparam logic [4:0] OP_SUB   = 5'h03;
  localparam logic [4:0] OP_SUBHI = 5'h04;
  localparam logic [4:0] OP_AND   = 5'h05;
  localparam logic [4:0] OP_OR    = 5'h06;
  localparam logic [4:0] OP_XOR   = 5'h07;
  localparam logic [4:0] OP_NOT   = 5'h08;
  localparam logic [4:0] OP_SHL   = 5'h09;
  localparam logic [4:0] OP_USHR  = 5'h0a;
  localparam logic [4:0] OP_ISHR  = 5'h0b;
  localparam logic [4:0] OP_ROT   = 5'h0c;
  localparam logic [4:0] OP_MUL8  = 5'h0d;
  localparam logic [4:0] OP_MIN   = 5'h0e;
  localparam logic [4:0] OP_MAX   = 5'h0f;
  localparam logic [4:0] OP_CMP   = 5'h10;
  localparam logic [4:0] OP_MOVI  = 5'h11;
  localparam logic [4:0] OP_ALU2  = 5'h13;
  localparam logic [4:0] OP_MSB   = 5'h14;

  typedef struct packed {
    logic        writes;
    logic [4:0]  op;
    logic [4:0]  dst;
    logic        rep;
    logic        use_imm;
    logic [4:0]  movi_sh;
    logic [15:0] imm;
  } dec_t;
endpackage

// File: rtl/mcalu_decode.sv
module mcalu_decode
  import mcalu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec,
  output logic [4:0]  src_a,
  output logic [4:0]  src_b
);
  logic [5:0] hdr;
  logic [4:0] opc;
  logic [4:0] sel;

  assign hdr   = instr[31:26];
  assign opc   = hdr[5:1];
  assign sel   = instr[4:0];
  assign src_a = instr[25:21];
  assign src_b = instr[20:16];

  always_comb begin
    dec         = '0;
    dec.imm     = instr[15:0];
    dec.movi_sh = instr[25:21];
    if (hdr < CTRL_HDR_BASE) begin
      dec.rep = hdr[0];
      if (opc == OP_ALU2) begin
        dec.op      = sel;
        dec.dst     = instr[15:11];
        dec.use_imm = 1'b0;
        dec.writes  = ((sel >= OP_ADD) && (sel <= OP_CMP)) || (sel == OP_MSB);
      end else begin
        dec.op      = opc;
        dec.dst     = instr[20:16];
        dec.use_imm = 1'b1;
        dec.writes  = (opc >= OP_ADD) && (opc <= OP_MOVI);
      end
    end
  end
endmodule

// File: rtl/mcalu_exec.sv
module mcalu_exec
  import mcalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [15:0]       imm,
  input  logic [4:0]        movi_sh,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              cy_we,
  output logic              cy_next
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]     sh;
  logic [DATA_W:0]     sum_lo;
  logic [2*DATA_W-1:0] rot_dbl;
  logic [2*MUL_W-1:0]  prod;
  logic [SH_W-1:0]     msb_idx;

  assign sh      = b[SH_W-1:0];
  assign sum_lo  = {1'b0, a} + {1'b0, b};
  assign rot_dbl = {a, a} << sh;
  assign prod    = a[MUL_W-1:0] * b[MUL_W-1:0];

  always_comb begin
    msb_idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (b[i]) msb_idx = SH_W'(i);
    end
  end

  always_comb begin
    res     = '0;
    cy_we   = 1'b0;
    cy_next = cy_in;
    case (op)
      OP_ADD: begin
        res     = sum_lo[DATA_W-1:0];
        cy_we   = 1'b1;
        cy_next = sum_lo[DATA_W];
      end
      OP_ADDHI: res = a + b + DATA_W'(cy_in);
      OP_SUB: begin
        res     = a - b;
        cy_we   = 1'b1;
        cy_next = (a < b);
      end
      OP_SUBHI: res = a - b - DATA_W'(cy_in);
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_NOT:   res = ~b;
      OP_SHL:   res = a << sh;
      OP_USHR:  res = a >> sh;
      OP_ISHR:  res = $unsigned($signed(a) >>> sh);
      OP_ROT:   res = rot_dbl[2*DATA_W-1:DATA_W];
      OP_MUL8:  res = DATA_W'(prod);
      OP_MIN:   res = (a < b) ? a : b;
      OP_MAX:   res = (a > b) ? a : b;
      OP_CMP:   res = (a == b) ? DATA_W'(0) : ((a > b) ? DATA_W'(1) : DATA_W'(2));
      OP_MOVI:  res = DATA_W'(imm) << movi_sh;
      OP_MSB:   res = DATA_W'(msb_idx);
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/mcode_alu.sv
module mcode_alu
  import mcalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  output logic [4:0]        src_a_idx,
  output logic [4:0]        src_b_idx,
  input  logic [DATA_W-1:0] src_a_data,
  input  logic [DATA_W-1:0] src_b_data,
  output logic              wr_en,
  output logic [4:0]        wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              rep_flag
);
  dec_t              dec;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] res;
  logic              cy_we;
  logic              cy_next;
  logic              cy_q;

  mcalu_decode u_dec (
    .instr (instr),
    .dec   (dec),
    .src_a (src_a_idx),
    .src_b (src_b_idx)
  );

  assign opnd_b = dec.use_imm ? DATA_W'(dec.imm) : src_b_data;

  mcalu_exec #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_exe (
    .op      (dec.op),
    .a       (src_a_data),
    .b       (opnd_b),
    .imm     (dec.imm),
    .movi_sh (dec.movi_sh),
    .cy_in   (cy_q),
    .res     (res),
    .cy_we   (cy_we),
    .cy_next (cy_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      rep_flag <= 1'b0;
      cy_q     <= 1'b0;
    end else begin
      wr_en <= instr_valid && dec.writes;
      if (instr_valid) begin
        wr_idx   <= dec.dst;
        wr_data  <= res;
        rep_flag <= dec.rep;
        if (dec.writes && cy_we) cy_q <= cy_next;
      end
    end
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !wr_en); // R2
  AST_CTRL_HDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[31:30] == 2'b11) |=> (!wr_en && !rep_flag)); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid || !(dec.op == OP_ADD || dec.op == OP_SUB) || !dec.writes) |=> $stable(cy_q)); // R4
  AST_CMP_CODE: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[31:27] == OP_CMP) |=> (wr_en && wr_data <= DATA_W'(2))); // R7
  AST_MSB_BOUND: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[31:27] == OP_ALU2 && instr[4:0] == OP_MSB) |=> (wr_en && wr_data < DATA_W'(DATA_W))); // R10
  AST_MUL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr[31:27] == OP_MUL8) |=> (wr_data >> (2*MUL_W)) == '0); // R6
endmodule

// File: tb/sim_mcode_alu.sv
module sim_mcode_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  src_a_idx, src_b_idx;
  logic [31:0] src_a_data, src_b_data;
  logic        wr_en, rep_flag;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [31:0] rf [32];
  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;

  assign src_a_data = rf[src_a_idx];
  assign src_b_data = rf[src_b_idx];

  mcode_alu u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .src_a_data(src_a_data), .src_b_data(src_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rep_flag(rep_flag)
  );

  function automatic logic [31:0] enc_i(input logic [4:0] op, input logic rep,
      input logic [4:0] src, input logic [4:0] dst, input logic [15:0] imm);
    return {op, rep, src, dst, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] sel, input logic [4:0] s1,
      input logic [4:0] s2, input logic [4:0] dst, input logic [1:0] xm, input logic [3:0] pad);
    return {5'h13, 1'b0, s1, s2, dst, xm, pad, sel};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic expw(input string tag, input logic [31:0] w, input logic [4:0] dst,
      input logic [31:0] data);
    run(w);
    chk({tag, " wr_en"}, {31'd0, wr_en}, 32'd1);
    chk({tag, " wr_idx"}, {27'd0, wr_idx}, {27'd0, dst});
    chk({tag, " wr_data"}, wr_data, data);
  endtask

  task automatic expnone(input string tag, input logic [31:0] w);
    run(w);
    chk({tag, " no write"}, {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12 wr_en after reset", {31'd0, wr_en}, 32'd0);
    chk("R12 rep_flag after reset", {31'd0, rep_flag}, 32'd0);
    expw("R12 flag cleared ADDHI", enc_i(5'h02, 1'b0, 5'd5, 5'd7, 16'd0), 5'd7, 32'd5);
  endtask

  task automatic t_logic;
    expw("R3 ADD", enc_i(5'h01, 1'b0, 5'd3, 5'd10, 16'h0008), 5'd10, 32'h12345680);
    expw("R3 SUB", enc_i(5'h03, 1'b0, 5'd3, 5'd11, 16'h0078), 5'd11, 32'h12345600);
    expw("R3 AND", enc_i(5'h05, 1'b0, 5'd3, 5'd12, 16'hFF0F), 5'd12, 32'h00005608);
    expw("R3 OR",  enc_i(5'h06, 1'b0, 5'd3, 5'd13, 16'h8001), 5'd13, 32'h1234D679);
    expw("R3 XOR", enc_i(5'h07, 1'b0, 5'd3, 5'd14, 16'hFFFF), 5'd14, 32'h1234A987);
  endtask

  task automatic t_carry;
    expw("R4 ADD carry out", enc_i(5'h01, 1'b0, 5'd1, 5'd2, 16'd1), 5'd2, 32'h0);
    expw("R4 AND keeps flag", enc_i(5'h05, 1'b0, 5'd5, 5'd3, 16'd1), 5'd3, 32'd1);
    expw("R4 ADDHI with carry", enc_i(5'h02, 1'b0, 5'd5, 5'd4, 16'd0), 5'd4, 32'd6);
    expw("R4 ADD no carry", enc_i(5'h01, 1'b0, 5'd5, 5'd4, 16'd1), 5'd4, 32'd6);
    expw("R4 ADDHI no carry", enc_i(5'h02, 1'b0, 5'd5, 5'd4, 16'd0), 5'd4, 32'd5);
    expw("R4 SUB borrow", enc_i(5'h03, 1'b0, 5'd5, 5'd4, 16'd6), 5'd4, 32'hFFFFFFFF);
    expw("R4 SUBHI with borrow", enc_i(5'h04, 1'b0, 5'd5, 5'd4, 16'd2), 5'd4, 32'd2);
    expw("R4 SUB no borrow", enc_i(5'h03, 1'b0, 5'd5, 5'd4, 16'd1), 5'd4, 32'd4);
    expw("R4 SUBHI no borrow", enc_i(5'h04, 1'b0, 5'd5, 5'd4, 16'd0), 5'd4, 32'd5);
  endtask

  task automatic t_shift;
    expw("R5 SHL",  enc_i(5'h09, 1'b0, 5'd3, 5'd6, 16'd4), 5'd6, 32'h23456780);
    expw("R5 USHR", enc_i(5'h0a, 1'b0, 5'd2, 5'd6, 16'd4), 5'd6, 32'h08000001);
    expw("R5 ISHR", enc_i(5'h0b, 1'b0, 5'd2, 5'd6, 16'd4), 5'd6, 32'hF8000001);
    expw("R5 ROT 8", enc_i(5'h0c, 1'b0, 5'd3, 5'd6, 16'd8), 5'd6, 32'h34567812);
    expw("R5 ROT 0", enc_i(5'h0c, 1'b0, 5'd3, 5'd6, 16'd0), 5'd6, 32'h12345678);
    expw("R5 ROT 31", enc_i(5'h0c, 1'b0, 5'd2, 5'd6, 16'd31), 5'd6, 32'h40000008);
  endtask

  task automatic t_misc;
    expw("R6 NOT", enc_i(5'h08, 1'b0, 5'd3, 5'd8, 16'h00F0), 5'd8, 32'hFFFFFF0F);
    expw("R6 NOT other src", enc_i(5'h08, 1'b0, 5'd1, 5'd8, 16'h00F0), 5'd8, 32'hFFFFFF0F);
    expw("R6 MUL8", enc_i(5'h0d, 1'b0, 5'd6, 5'd8, 16'h0102), 5'd8, 32'h000001FE);
    expw("R6 MUL8 max", enc_i(5'h0d, 1'b0, 5'd1, 5'd8, 16'h00FF), 5'd8, 32'h0000FE01);
  endtask

  task automatic t_cmp;
    expw("R7 MIN", enc_i(5'h0e, 1'b0, 5'd3, 5'd9, 16'h0100), 5'd9, 32'h00000100);
    expw("R7 MAX", enc_i(5'h0f, 1'b0, 5'd3, 5'd9, 16'h0100), 5'd9, 32'h12345678);
    expw("R7 MIN unsigned", enc_i(5'h0e, 1'b0, 5'd2, 5'd9, 16'h0011), 5'd9, 32'h00000011);
    expw("R7 CMP equal", enc_i(5'h10, 1'b0, 5'd5, 5'd9, 16'd5), 5'd9, 32'd0);
    expw("R7 CMP greater", enc_i(5'h10, 1'b0, 5'd5, 5'd9, 16'd3), 5'd9, 32'd1);
    expw("R7 CMP less", enc_i(5'h10, 1'b0, 5'd5, 5'd9, 16'd9), 5'd9, 32'd2);
    expw("R7 CMP unsigned", enc_i(5'h10, 1'b0, 5'd2, 5'd9, 16'h0010), 5'd9, 32'd1);
  endtask

  task automatic t_movi;
    expw("R8 MOVI sh16", enc_i(5'h11, 1'b0, 5'd16, 5'd15, 16'hABCD), 5'd15, 32'hABCD0000);
    expw("R8 MOVI sh20", enc_i(5'h11, 1'b0, 5'd20, 5'd15, 16'hABCD), 5'd15, 32'hBCD00000);
    expw("R8 MOVI sh0", enc_i(5'h11, 1'b0, 5'd0, 5'd15, 16'h1234), 5'd15, 32'h00001234);
  endtask

  task automatic t_reg;
    @(negedge clk);
    instr = enc_r(5'h03, 5'd3, 5'd5, 5'd9, 2'b11, 4'hF);
    #1;
    chk("R9 src_a_idx", {27'd0, src_a_idx}, 32'd3);
    chk("R9 src_b_idx", {27'd0, src_b_idx}, 32'd5);
    expw("R9 SUB two-reg pad set", enc_r(5'h03, 5'd3, 5'd5, 5'd9, 2'b11, 4'hF), 5'd9, 32'h12345673);
    expw("R9 SUB two-reg pad clear", enc_r(5'h03, 5'd3, 5'd5, 5'd9, 2'b00, 4'h0), 5'd9, 32'h12345673);
    expw("R9 XOR two-reg", enc_r(5'h07, 5'd3, 5'd1, 5'd21, 2'b01, 4'h5), 5'd21, 32'hEDCBA987);
  endtask

  task automatic t_msb;
    rf[7] = 32'h00010000;
    expw("R10 MSB bit16", enc_r(5'h14, 5'd0, 5'd7, 5'd22, 2'b00, 4'h0), 5'd22, 32'd16);
    expw("R10 MSB zero", enc_r(5'h14, 5'd3, 5'd0, 5'd22, 2'b00, 4'h0), 5'd22, 32'd0);
    expw("R10 MSB top", enc_r(5'h14, 5'd0, 5'd2, 5'd22, 2'b00, 4'h0), 5'd22, 32'd31);
    expnone("R10 MSB in imm format", enc_i(5'h14, 1'b0, 5'd2, 5'd22, 16'h0));
  endtask

  task automatic t_unknown;
    expnone("R11 NOP", enc_i(5'h00, 1'b0, 5'd3, 5'd1, 16'h1));
    expnone("R11 imm opcode 0x12", enc_i(5'h12, 1'b0, 5'd3, 5'd1, 16'h1));
    expnone("R11 sel 0x11", enc_r(5'h11, 5'd3, 5'd5, 5'd1, 2'b00, 4'h0));
    expnone("R11 sel 0x00", enc_r(5'h00, 5'd3, 5'd5, 5'd1, 2'b00, 4'h0));
    run(32'h0);
    @(negedge clk);
    chk("R2 idle no write", {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_rep;
    expw("R1 ADD with rep", enc_i(5'h01, 1'b1, 5'd5, 5'd4, 16'd2), 5'd4, 32'd7);
    chk("R1 rep set", {31'd0, rep_flag}, 32'd1);
    run({6'h31, 26'h3FFFFFF});
    chk("R1 ctrl header rep", {31'd0, rep_flag}, 32'd0);
    chk("R1 ctrl header no write", {31'd0, wr_en}, 32'd0);
    expw("R1 ADD no rep", enc_i(5'h01, 1'b0, 5'd5, 5'd4, 16'd2), 5'd4, 32'd7);
    chk("R1 rep clear", {31'd0, rep_flag}, 32'd0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = i * 32'h01010101;
    rf[0] = 32'h0;
    rf[1] = 32'hFFFFFFFF;
    rf[2] = 32'h80000010;
    rf[3] = 32'h12345678;
    rf[5] = 32'd5;
    rf[6] = 32'h123456FF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_logic();
    t_carry();
    t_shift();
    t_misc();
    t_cmp();
    t_movi();
    t_reg();
    t_msb();
    t_unknown();
    t_rep();
    summary();
  end
endmodule